// File: doc/BRIEF.md
# Request-Response Clock Domain Bridge

This block moves a single bus transaction from a fast source clock domain into a system clock domain and brings the answer back. The source side raises a request for one cycle together with a payload word. The payload carries a write command bit, a read command bit, an address and a 32-bit write word. On the system side the bridge drives the address and write word and fires a one-cycle write strobe, a one-cycle read strobe, or both. One cycle after the strobe cycle it samples the 32-bit read word. It then sends an acknowledge back to the source domain together with that word.

Only a toggle bit crosses in each direction, through a chain of synchronizer flip-flops. The payload and the returned word are held in registers that do not change while the other domain reads them. The source side must not issue a new request before the acknowledge of the previous one. It may issue the next request in the very cycle the acknowledge is high, which gives the highest throughput. The address width and the synchronizer depth are parameters. The data paths are fixed at 32 bits.

Top module: `txn_xdom_bridge`

## Requirements
- R1: After either reset is released, srcAck, sysWrEn and sysRdEn are low, srcRdData and sysWrData read zero, and no strobe fires until a request is made.
- R2: The payload is packed with the write command at bit ADDR_W+33, the read command at bit ADDR_W+32, the address in bits ADDR_W+31 down to 32, and the write word in bits 31 down to 0. During a strobe, sysAddr shows the address field of that request.
- R3: Each one-cycle srcReq pulse produces exactly one transfer and exactly one acknowledge.
- R4: When the write command bit is set, sysWrEn is high for exactly one sysClk cycle per request, with sysWrData equal to the write field of the payload.
- R5: When the read command bit is set, sysRdEn is high for exactly one sysClk cycle. sysRdData is sampled at the sysClk edge that ends the cycle after the read strobe, and that sampled word is returned on srcRdData.
- R6: For a request with the read bit set and the write bit clear, the write field is ignored: sysWrData keeps the value of the last write.
- R7: srcAck is high for exactly one srcClk cycle per transaction. srcRdData is stable while srcAck is high and holds its value until the next acknowledge.
- R8: When both command bits are set, sysWrEn and sysRdEn fire in the same sysClk cycle, and the returned word follows the sampling rule of R5.
- R9: When neither command bit is set, no strobe fires, but the transaction is still acknowledged.
- R10: A new request may be issued in the srcClk cycle in which srcAck is high. Transactions complete in issue order for any ratio between the two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcClk | input | 1 | Source domain clock |
| srcRstN | input | 1 | Source domain asynchronous reset, active low |
| srcReq | input | 1 | One-cycle request pulse |
| srcPayload | input | ADDR_W+34 | Command bits, address and write word |
| srcAck | output | 1 | One-cycle acknowledge pulse |
| srcRdData | output | 32 | Returned word, valid with srcAck |
| sysClk | input | 1 | System domain clock |
| sysRstN | input | 1 | System domain asynchronous reset, active low |
| sysAddr | output | ADDR_W | Address presented to the system side |
| sysWrData | output | 32 | Write word presented to the system side |
| sysWrEn | output | 1 | One-cycle write strobe |
| sysRdEn | output | 1 | One-cycle read strobe |
| sysRdData | input | 32 | Read word from system-side storage with one cycle of latency |

## Verification
Two functions can fall in the same source cycle: the payload register can load the next request while the acknowledge of the previous one is being shown. The bench provokes this by issuing the next request as soon as it samples srcAck high, across several system clock periods that are both faster and slower than the source clock. It judges the result by checking that each returned word matches a reference memory updated in issue order, and that the write value held on a read still equals the previous write. Within the system domain, both strobes share a cycle when both command bits are set. Those requests must return the stored word from before the write.

// File: rtl/xbridge_pkg.sv
package xbridge_pkg;
  localparam int DATA_W = 32;

  // strobes from the control to the datapath
  typedef struct packed {
    logic srcLoad;     // source domain: capture payload
    logic sysTake;     // system domain: present request, fire strobes
    logic sysCapture;  // system domain: sample read word
  } dpStrobe_t;
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stageD;
    logic stageQ;
    if (i == 0) begin : g_first
      assign stageD = d;
    end else begin : g_next
      assign stageD = g_stage[i-1].stageQ;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= 1'b0;
      else       stageQ <= stageD;
    end
  end

  assign q = g_stage[STAGES-1].stageQ;
endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import xbridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       srcClk,
  input  logic       srcRstN,
  input  logic       srcReq,
  output logic       srcAck,
  input  logic       sysClk,
  input  logic       sysRstN,
  output dpStrobe_t  strobe
);
  // source domain
  logic reqToggle;
  logic ackSync;
  logic ackSeen;

  // system domain
  logic reqSync;
  logic reqSeen;
  logic newReq;
  logic strobePhase;
  logic capturePhase;
  logic ackToggle;

  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN) begin
      reqToggle <= 1'b0;
      ackSeen   <= 1'b0;
    end else begin
      if (srcReq) reqToggle <= ~reqToggle;
      ackSeen <= ackSync;
    end
  end

  bridge_sync #(.STAGES(SYNC_STAGES)) uAckSync (
    .clk (srcClk),
    .rstN(srcRstN),
    .d   (ackToggle),
    .q   (ackSync)
  );

  assign srcAck = ackSync ^ ackSeen;

  bridge_sync #(.STAGES(SYNC_STAGES)) uReqSync (
    .clk (sysClk),
    .rstN(sysRstN),
    .d   (reqToggle),
    .q   (reqSync)
  );

  assign newReq = reqSync ^ reqSeen;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      reqSeen      <= 1'b0;
      strobePhase  <= 1'b0;
      capturePhase <= 1'b0;
      ackToggle    <= 1'b0;
    end else begin
      reqSeen      <= reqSync;
      strobePhase  <= newReq;
      capturePhase <= strobePhase;
      if (capturePhase) ackToggle <= ~ackToggle;
    end
  end

  always_comb begin
    strobe.srcLoad    = srcReq;
    strobe.sysTake    = newReq;
    strobe.sysCapture = capturePhase;
  end

  // R7: acknowledge lasts one source cycle
  a_r7_ack_single : assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcAck |=> !srcAck);

  // R10: no new request while one is outstanding, except in the ack cycle
  a_r10_req_when_idle : assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcReq |-> ((reqToggle == ackSeen) || srcAck));

  // R3: one request is taken once on the system side
  a_r3_take_single : assert property (@(posedge sysClk) disable iff (!sysRstN)
    newReq |=> !newReq);
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath
  import xbridge_pkg::*;
#(
  parameter int ADDR_W = 22,
  localparam int PAY_W  = ADDR_W + DATA_W + 2
) (
  input  logic              srcClk,
  input  logic              srcRstN,
  input  logic [PAY_W-1:0]  srcPayload,
  input  logic              sysClk,
  input  logic              sysRstN,
  input  dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] sysAddr,
  output logic [DATA_W-1:0] sysWrData,
  output logic              sysWrEn,
  output logic              sysRdEn,
  input  logic [DATA_W-1:0] sysRdData,
  output logic [DATA_W-1:0] retData
);
  localparam int WR_BIT  = PAY_W - 1;
  localparam int RD_BIT  = PAY_W - 2;
  localparam int ADDR_LO = DATA_W;
  localparam int ADDR_HI = DATA_W + ADDR_W - 1;

  logic [PAY_W-1:0] holdQ;
  logic             holdWr;
  logic             holdRd;

  // held from the request until the next request; read across domains
  always_ff @(posedge srcClk or negedge srcRstN) begin
    if (!srcRstN)            holdQ <= '0;
    else if (strobe.srcLoad) holdQ <= srcPayload;
  end

  assign holdWr = holdQ[WR_BIT];
  assign holdRd = holdQ[RD_BIT];

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      sysAddr   <= '0;
      sysWrData <= '0;
      sysWrEn   <= 1'b0;
      sysRdEn   <= 1'b0;
      retData   <= '0;
    end else begin
      sysWrEn <= strobe.sysTake & holdWr;
      sysRdEn <= strobe.sysTake & holdRd;
      if (strobe.sysTake) sysAddr <= holdQ[ADDR_HI:ADDR_LO];
      if (strobe.sysTake && holdWr) sysWrData <= holdQ[DATA_W-1:0];
      if (strobe.sysCapture) retData <= sysRdData;
    end
  end

  // R4: write strobe is a single cycle
  a_r4_wr_single : assert property (@(posedge sysClk) disable iff (!sysRstN)
    sysWrEn |=> !sysWrEn);

  // R5: read strobe is a single cycle
  a_r5_rd_single : assert property (@(posedge sysClk) disable iff (!sysRstN)
    sysRdEn |=> !sysRdEn);

  // R6: a pure read leaves the write word untouched
  a_r6_wrdata_kept : assert property (@(posedge sysClk) disable iff (!sysRstN)
    (sysRdEn && !sysWrEn) |-> $stable(sysWrData));
endmodule

// File: rtl/txn_xdom_bridge.sv
module txn_xdom_bridge
  import xbridge_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       srcClk,
  input  logic                       srcRstN,
  input  logic                       srcReq,
  input  logic [ADDR_W+DATA_W+1:0]   srcPayload,
  output logic                       srcAck,
  output logic [DATA_W-1:0]          srcRdData,
  input  logic                       sysClk,
  input  logic                       sysRstN,
  output logic [ADDR_W-1:0]          sysAddr,
  output logic [DATA_W-1:0]          sysWrData,
  output logic                       sysWrEn,
  output logic                       sysRdEn,
  input  logic [DATA_W-1:0]          sysRdData
);
  dpStrobe_t strobe;

  bridge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .srcClk (srcClk),
    .srcRstN(srcRstN),
    .srcReq (srcReq),
    .srcAck (srcAck),
    .sysClk (sysClk),
    .sysRstN(sysRstN),
    .strobe (strobe)
  );

  bridge_datapath #(.ADDR_W(ADDR_W)) uData (
    .srcClk    (srcClk),
    .srcRstN   (srcRstN),
    .srcPayload(srcPayload),
    .sysClk    (sysClk),
    .sysRstN   (sysRstN),
    .strobe    (strobe),
    .sysAddr   (sysAddr),
    .sysWrData (sysWrData),
    .sysWrEn   (sysWrEn),
    .sysRdEn   (sysRdEn),
    .sysRdData (sysRdData),
    .retData   (srcRdData)
  );

  // R7: returned word is settled when the acknowledge is seen
  a_r7_data_stable : assert property (@(posedge srcClk) disable iff (!srcRstN)
    srcAck |-> $stable(srcRdData));
endmodule

// File: tb/tb_txn_xdom_bridge.sv
`timescale 1ns/1ps
module tb_txn_xdom_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 22;
  localparam int MEM_N      = 16;

  logic              srcClk = 1'b0;
  logic              sysClk = 1'b0;
  logic              srcRstN = 1'b0;
  logic              sysRstN = 1'b0;
  logic              srcReq = 1'b0;
  logic [ADDR_W+33:0] srcPayload = '0;
  logic              srcAck;
  logic [31:0]       srcRdData;
  logic [ADDR_W-1:0] sysAddr;
  logic [31:0]       sysWrData;
  logic              sysWrEn;
  logic              sysRdEn;
  logic [31:0]       sysRdData = '0;

  int sysHalf = 7;

  txn_xdom_bridge #(.ADDR_W(ADDR_W)) dut (
    .srcClk(srcClk), .srcRstN(srcRstN), .srcReq(srcReq), .srcPayload(srcPayload),
    .srcAck(srcAck), .srcRdData(srcRdData), .sysClk(sysClk), .sysRstN(sysRstN),
    .sysAddr(sysAddr), .sysWrData(sysWrData), .sysWrEn(sysWrEn), .sysRdEn(sysRdEn),
    .sysRdData(sysRdData)
  );

  always #(CLK_PERIOD/2) srcClk = ~srcClk;
  always begin #(sysHalf) sysClk = ~sysClk; end

  // system-side storage, one cycle read latency, read before write
  logic [31:0] mem [MEM_N];
  always @(posedge sysClk) begin
    if (sysRdEn) sysRdData <= mem[sysAddr[3:0]];
    if (sysWrEn) mem[sysAddr[3:0]] <= sysWrData;
  end

  // strobe monitor
  int wrCount = 0, rdCount = 0, widthErr = 0, ackCount = 0;
  logic prevWr = 1'b0, prevRd = 1'b0;
  logic [ADDR_W-1:0] wrAddrSeen, rdAddrSeen;
  logic [31:0] wrDataSeen, wrDataAtRd;
  always @(negedge sysClk) begin
    if (sysWrEn) begin wrCount++; wrAddrSeen = sysAddr; wrDataSeen = sysWrData; end
    if (sysRdEn) begin rdCount++; rdAddrSeen = sysAddr; wrDataAtRd = sysWrData; end
    if ((sysWrEn && prevWr) || (sysRdEn && prevRd)) widthErr++;
    prevWr = sysWrEn;
    prevRd = sysRdEn;
  end
  always @(negedge srcClk) if (srcAck) ackCount++;

  int checks = 0, errors = 0;
  bit aborted = 0;
  logic [31:0] refMem [MEM_N];
  logic [31:0] lastWr = '0;
  logic [31:0] lastAck = '0;
  int txnCount = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W+33:0] mkPayload(input bit wr, input bit rd,
      input logic [ADDR_W-1:0] addr, input logic [31:0] data);
    return {wr, rd, addr, data};
  endfunction

  function automatic logic [31:0] expRead(input logic [ADDR_W-1:0] addr);
    return refMem[addr[3:0]];
  endfunction

  task automatic runTxn(input bit wr, input bit rd, input logic [ADDR_W-1:0] addr,
                        input logic [31:0] data);
    int wr0 = wrCount;
    int rd0 = rdCount;
    int waited = 0;
    logic [31:0] expData = expRead(addr);
    logic [31:0] prevWr0 = lastWr;
    if (aborted) return;
    if (wr) begin refMem[addr[3:0]] = data; lastWr = data; end
    txnCount++;
    srcPayload = mkPayload(wr, rd, addr, data);
    srcReq = 1'b1;
    @(negedge srcClk);
    srcReq = 1'b0;
    check(srcAck == 1'b0, "R7 ack single cycle", {63'b0, srcAck}, 64'd0);
    check(srcRdData == lastAck, "R7 data held", {32'b0, srcRdData}, {32'b0, lastAck});
    while (!srcAck && waited < 4000) begin
      @(negedge srcClk);
      waited++;
    end
    if (!srcAck) begin
      check(1'b0, "R3 acknowledge missing", 64'd0, 64'd1);
      aborted = 1;
      return;
    end
    lastAck = srcRdData;
    check(wrCount - wr0 == int'(wr), "R4 write strobe count", 64'(wrCount - wr0), 64'(wr));
    check(rdCount - rd0 == int'(rd), "R5 read strobe count", 64'(rdCount - rd0), 64'(rd));
    if (!wr && !rd)
      check(wrCount == wr0 && rdCount == rd0, "R9 no strobe", 64'(wrCount - wr0), 64'd0);
    if (wr) begin
      check(wrAddrSeen == addr, "R2 write address", 64'(wrAddrSeen), 64'(addr));
      check(wrDataSeen == data, "R4 write data", 64'(wrDataSeen), 64'(data));
    end
    if (rd) begin
      check(rdAddrSeen == addr, "R2 read address", 64'(rdAddrSeen), 64'(addr));
      check(srcRdData == expData, wr ? "R8 combined read data" : "R5 R10 read data",
            64'(srcRdData), 64'(expData));
      if (!wr)
        check(wrDataAtRd == prevWr0, "R6 write word kept", 64'(wrDataAtRd), 64'(prevWr0));
    end
    check(widthErr == 0, "R4 R5 strobe width", 64'(widthErr), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge srcClk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int halves [5] = '{2, 5, 9, 17, 31};
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < MEM_N; i++) begin mem[i] = '0; refMem[i] = '0; end
    repeat (3) @(negedge srcClk);
    srcRstN = 1'b1;
    sysRstN = 1'b1;
    repeat (10) @(negedge srcClk);
    check(srcAck == 1'b0, "R1 ack low", {63'b0, srcAck}, 64'd0);
    check(!sysWrEn && !sysRdEn, "R1 strobes low", {62'b0, sysWrEn, sysRdEn}, 64'd0);
    check(srcRdData == '0 && sysWrData == '0, "R1 data zero", 64'(srcRdData), 64'd0);
    check(wrCount == 0 && rdCount == 0, "R1 no strobe", 64'(wrCount + rdCount), 64'd0);

    // directed corners
    runTxn(1'b0, 1'b1, 22'h000005, 32'hdead_beef);            // untouched, reads 0
    runTxn(1'b1, 1'b0, {ADDR_W{1'b1}}, 32'hffff_ffff);        // max address
    runTxn(1'b0, 1'b1, {ADDR_W{1'b1}}, 32'h1234_5678);        // write field ignored
    runTxn(1'b1, 1'b1, 22'h0a_000f, 32'h0bad_cafe);           // both flags
    runTxn(1'b0, 1'b1, 22'h00_000f, 32'h0);                   // sees new word
    runTxn(1'b0, 1'b0, 22'h15_5555, 32'haaaa_aaaa);           // neither flag
    runTxn(1'b1, 1'b0, 22'h000003, 32'h0);                    // zero data

    // random, back-to-back, over several clock ratios
    foreach (halves[h]) begin
      sysHalf = halves[h];
      for (int n = 0; n < 40; n++) begin
        bit wr = 1'($urandom_range(0, 1));
        bit rd = 1'($urandom_range(0, 1));
        logic [ADDR_W-1:0] a = ADDR_W'($urandom);
        runTxn(wr, rd, a, $urandom);
      end
    end

    repeat (20) @(negedge srcClk);
    check(ackCount == txnCount, "R3 one ack per request", 64'(ackCount), 64'(txnCount));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule